// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors held in system memory. Each descriptor is two 32-bit big-endian words. It points at one data buffer. The walker gathers consecutive buffers into frames and sends every frame byte by byte on a ready/valid stream that marks the frame's final byte. It uses one simple 32-bit memory master port for all descriptor reads, descriptor write-backs and buffer fetches.

Software sets the enable bit, programs the ring start address and then issues an activate write. The walker then processes descriptors one after another until it reaches one that hardware does not own. It leaves its current pointer on that descriptor, so the next activate resumes from the same place. Three single-cycle event outputs report to the interrupt logic: buffer consumed, frame completed, and frame cut short at the length limit.

Top module: `txring_walker`

## Requirements
- R1: After reset `busy`, `mem_req` and `tx_valid` are low, the enable is clear, and the ring start and current pointer are zero.
- R2: An activate write (`cfg_sel`=2) starts a walk only when the enable bit (bit 1 of the control write, `cfg_sel`=0) is set. Otherwise no memory request is issued and `busy` stays low.
- R3: Descriptor word 0 carries the flags in bits 31:16 and the byte length in bits 15:0. Word 1 at offset +4 is the buffer address. Flag bit 15 (word bit 31) means the descriptor is owned by hardware. The walk stops at the first descriptor without it and keeps that address as the current pointer.
- R4: A buffer's bytes come out on `tx_data` starting at its word-aligned address, most significant byte of each word first. Exactly the buffer length is emitted, unless R9 cuts it short.
- R5: `tx_last` is high only on the final byte of a buffer whose flag bit 11 (last in frame) is set.
- R6: After a buffer is consumed, word 0 of its descriptor is written back with bit 31 cleared and all other flag and length bits unchanged, and `ev_tx_buf` pulses once.
- R7: `ev_tx_frame` pulses, together with `ev_tx_buf`, for each consumed descriptor that has the last-in-frame flag.
- R8: The next descriptor address is the ring start when flag bit 13 (wrap) is set, and the current address plus 8 otherwise.
- R9: When the bytes of a frame would exceed `MAX_FRAME`, the buffer is cut to the remaining room, `ev_tx_babble` pulses, and the frame's byte count never passes `MAX_FRAME`.
- R10: A ring start write (`cfg_sel`=1) stores the value with bits 1:0 forced to zero and loads the current pointer with it. Every memory address issued is word aligned.
- R11: A memory request keeps `mem_req`, `mem_addr` and `mem_we` steady until `mem_ready` is seen.
- R12: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 ring start, 2 activate |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| ev_tx_buf | output | 1 | Pulse: buffer consumed |
| ev_tx_frame | output | 1 | Pulse: frame completed |
| ev_tx_babble | output | 1 | Pulse: frame truncated |
| busy | output | 1 | A walk is in progress |

## Verification
The assertions assume the memory returns read data in the same cycle it raises `mem_ready`. They also assume software writes the ring start only while `busy` is low, and that a last-in-frame buffer always has at least one byte left after truncation. The bench models memory as a word array that answers every other cycle. It changes ring start and descriptors only between walks, and it makes every last-in-frame length fit the room left. `tx_ready` is withheld one cycle in four, so the stream hold property and the memory hold property are both exercised under back-pressure.

// File: rtl/txw_pkg.sv
// Shared constants and types for the transmit descriptor ring walker.
// Assumes 32-bit memory words and 8-byte descriptors.
package txw_pkg;
    localparam int WORD_BYTES  = 4;
    localparam int DESC_STRIDE = 8;
    localparam int BIT_OWN     = 15;
    localparam int BIT_WRAP    = 13;
    localparam int BIT_LAST    = 11;
    localparam int CTRL_EN_BIT = 1;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_RING = 2'd1;
    localparam logic [1:0] SEL_GO   = 2'd2;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DESC0,
        W_DESC1,
        W_FETCH,
        W_SEND,
        W_WBACK
    } walk_state_t;
endpackage

// File: rtl/txw_cfg_regs.sv
// Configuration registers: enable bit and ring start address.
// The activate strobe is gated by the enable bit held before the write.
// A ring start write also drives a load of the walker's current pointer.
module txw_cfg_regs
    import txw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              enable,
    output logic [ADDR_W-1:0] ring_base,
    output logic              base_load,
    output logic [ADDR_W-1:0] base_wval,
    output logic              go
);
    logic              en_q;
    logic [ADDR_W-1:0] base_q;
    logic              unused_bits;

    assign unused_bits = cfg_wdata[0];
    assign base_wval   = {cfg_wdata[ADDR_W-1:2], 2'b00};
    assign base_load   = cfg_wr && (cfg_sel == SEL_RING);
    assign go          = cfg_wr && (cfg_sel == SEL_GO) && en_q;
    assign enable      = en_q;
    assign ring_base   = base_q;

    // Hold the enable bit and the aligned ring start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
        end else begin
            if (cfg_wr && cfg_sel == SEL_CTRL) en_q <= cfg_wdata[CTRL_EN_BIT];
            if (base_load) base_q <= base_wval;
        end
    end
endmodule

// File: rtl/txw_byte_ser.sv
// Word-to-byte serializer: emits up to four bytes of a loaded word, MSB first,
// on a ready/valid stream. Assumes a load arrives only while it is empty.
module txw_byte_ser
    import txw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] word,
    input  logic [2:0]  nbytes,
    input  logic        last_in,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    output logic        idle
);
    logic [31:0] sh_q;
    logic [2:0]  cnt_q;
    logic        last_q;

    assign tx_valid = (cnt_q != 3'd0);
    assign tx_data  = sh_q[31:24];
    assign tx_last  = last_q && (cnt_q == 3'd1);
    assign idle     = (cnt_q == 3'd0);

    // Load a word, then shift one byte out per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= 3'd0;
            last_q <= 1'b0;
        end else if (load) begin
            sh_q   <= word;
            cnt_q  <= nbytes;
            last_q <= last_in;
        end else if (tx_valid && tx_ready) begin
            sh_q  <= sh_q << 8;
            cnt_q <= cnt_q - 3'd1;
        end
    end

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R12
    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> idle && nbytes != 3'd0 && nbytes <= 3'(WORD_BYTES)); // R4
endmodule

// File: rtl/txw_walk_fsm.sv
// Descriptor walker: reads descriptors, fetches buffer words into the
// serializer, writes back ownership and steps or wraps the ring.
// Assumes read data is valid in the cycle mem_ready is high, and that the
// ring start is only rewritten while idle.
module txw_walk_fsm
    import txw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_wval,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    input  logic              ser_idle,
    output logic              ser_load,
    output logic [31:0]       ser_word,
    output logic [2:0]        ser_nbytes,
    output logic              ser_last,
    output logic              ev_buf,
    output logic              ev_frame,
    output logic              ev_babble,
    output logic              busy
);
    localparam int CW = $clog2(MAX_FRAME + 1);

    walk_state_t       state_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [15:0]       flags_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain_q;
    logic [CW-1:0]     fcnt_q;
    logic              acc;
    logic [31:0]       room;
    logic              over;
    logic [LEN_W-1:0]  take;
    logic [1:0]        unused_rd;

    assign unused_rd  = mem_rdata[1:0];
    assign acc        = mem_req && mem_ready;
    assign room       = 32'(MAX_FRAME) - 32'(fcnt_q);
    assign over       = 32'(len_q) > room;
    assign take       = over ? LEN_W'(room) : len_q;
    assign busy       = (state_q != W_IDLE);
    assign ser_word   = mem_rdata;
    assign ser_load   = (state_q == W_FETCH) && acc;
    assign ser_nbytes = (remain_q >= LEN_W'(WORD_BYTES)) ? 3'(WORD_BYTES) : remain_q[2:0];
    assign ser_last   = flags_q[BIT_LAST] && (remain_q <= LEN_W'(WORD_BYTES));

    // Drive the memory master port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = {flags_q & ~(16'd1 << BIT_OWN), 16'(len_q)};
        case (state_q)
            W_DESC0: mem_req = 1'b1;
            W_DESC1: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + ADDR_W'(4);
            end
            W_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q;
            end
            W_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Step the walk, track frame bytes and raise the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= W_IDLE;
            cur_q     <= '0;
            ptr_q     <= '0;
            flags_q   <= '0;
            len_q     <= '0;
            remain_q  <= '0;
            fcnt_q    <= '0;
            ev_buf    <= 1'b0;
            ev_frame  <= 1'b0;
            ev_babble <= 1'b0;
        end else begin
            ev_buf    <= 1'b0;
            ev_frame  <= 1'b0;
            ev_babble <= 1'b0;
            case (state_q)
                W_IDLE: if (go) state_q <= W_DESC0;
                W_DESC0: if (acc) begin
                    flags_q <= mem_rdata[31:16];
                    len_q   <= LEN_W'(mem_rdata[15:0]);
                    state_q <= mem_rdata[16 + BIT_OWN] ? W_DESC1 : W_IDLE;
                end
                W_DESC1: if (acc) begin
                    ptr_q     <= {mem_rdata[ADDR_W-1:2], 2'b00};
                    remain_q  <= take;
                    fcnt_q    <= fcnt_q + CW'(take);
                    ev_babble <= over;
                    state_q   <= (take == '0) ? W_WBACK : W_FETCH;
                end
                W_FETCH: if (acc) begin
                    remain_q <= remain_q - LEN_W'(ser_nbytes);
                    ptr_q    <= ptr_q + ADDR_W'(WORD_BYTES);
                    state_q  <= W_SEND;
                end
                W_SEND: if (ser_idle) state_q <= (remain_q == '0) ? W_WBACK : W_FETCH;
                W_WBACK: if (acc) begin
                    ev_buf <= 1'b1;
                    if (flags_q[BIT_LAST]) begin
                        ev_frame <= 1'b1;
                        fcnt_q   <= '0;
                    end
                    cur_q   <= flags_q[BIT_WRAP] ? ring_base : cur_q + ADDR_W'(DESC_STRIDE);
                    state_q <= W_DESC0;
                end
                default: state_q <= W_IDLE;
            endcase
            if (base_load) cur_q <= base_wval;
        end
    end

    AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fcnt_q) <= 32'(MAX_FRAME)); // R9
endmodule

// File: rtl/txring_walker.sv
// Top of the transmit descriptor ring walker: configuration registers,
// descriptor walker and byte serializer. Assumes a single memory master
// port with request held until ready, and a byte stream sink with ready.
module txring_walker
    import txw_pkg::*;
#(
    parameter int MAX_FRAME = 2032
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        ev_tx_buf,
    output logic        ev_tx_frame,
    output logic        ev_tx_babble,
    output logic        busy
);
    localparam int AW = 32;

    logic          enable;
    logic [AW-1:0] ring_base;
    logic          base_load;
    logic [AW-1:0] base_wval;
    logic          go;
    logic          ser_idle;
    logic          ser_load;
    logic [31:0]   ser_word;
    logic [2:0]    ser_nbytes;
    logic          ser_last;

    txw_cfg_regs #(.ADDR_W(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .enable(enable), .ring_base(ring_base),
        .base_load(base_load), .base_wval(base_wval), .go(go)
    );

    txw_walk_fsm #(.ADDR_W(AW), .LEN_W(16), .MAX_FRAME(MAX_FRAME)) i_walk (
        .clk(clk), .rst_n(rst_n), .go(go), .base_load(base_load),
        .base_wval(base_wval), .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ser_idle(ser_idle), .ser_load(ser_load), .ser_word(ser_word),
        .ser_nbytes(ser_nbytes), .ser_last(ser_last),
        .ev_buf(ev_tx_buf), .ev_frame(ev_tx_frame), .ev_babble(ev_tx_babble),
        .busy(busy)
    );

    txw_byte_ser i_ser (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .word(ser_word),
        .nbytes(ser_nbytes), .last_in(ser_last), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .idle(ser_idle)
    );

    AST_GATED_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !busy |=> !busy); // R2
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R10
    AST_FRAME_EV: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_frame |-> ev_tx_buf); // R7
    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R5
endmodule

// File: tb/test_txring_walker.sv
module test_txring_walker;
    localparam int MAXF = 20;
    localparam logic [15:0] F_OWN = 16'h8000;
    localparam logic [15:0] F_WRP = 16'h2000;
    localparam logic [15:0] F_LST = 16'h0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, tx_ready;
    logic        ev_tx_buf, ev_tx_frame, ev_tx_babble, busy;

    logic [31:0] mem [0:255];
    logic        gate = 1'b0;
    logic [1:0]  rc = 2'd0;
    logic [7:0]  cap_d [0:255];
    logic        cap_l [0:255];
    int          cap_n = 0;
    int          n_buf = 0, n_frm = 0, n_bab = 0, n_req = 0;
    logic [7:0]  exp_d [0:63];
    logic        exp_l [0:63];
    int          exp_n;
    int          n_chk = 0, n_bad = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    txring_walker #(.MAX_FRAME(MAXF)) i_txring_walker (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_ready(tx_ready), .ev_tx_buf(ev_tx_buf),
        .ev_tx_frame(ev_tx_frame), .ev_tx_babble(ev_tx_babble), .busy(busy)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_ready = mem_req && gate;
    assign tx_ready  = (rc != 2'b11);

    function automatic logic [7:0] mbyte(int a);
        return 8'(a * 7 + 3);
    endfunction

    // Memory model, stall pattern and observation counters.
    always @(posedge clk) begin
        gate <= ~gate;
        rc   <= rc + 2'd1;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req) n_req <= n_req + 1;
        if (ev_tx_buf) n_buf <= n_buf + 1;
        if (ev_tx_frame) n_frm <= n_frm + 1;
        if (ev_tx_babble) n_bab <= n_bab + 1;
        if (tx_valid && tx_ready) begin
            cap_d[cap_n[7:0]] <= tx_data;
            cap_l[cap_n[7:0]] <= tx_last;
            cap_n <= cap_n + 1;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic activate();
        cfg_write(2'd2, 32'd0);
        for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic put_desc(input int a, input logic [15:0] f, input logic [15:0] len, input int p);
        mem[a >> 2]       = {f, len};
        mem[(a >> 2) + 1] = 32'(p);
    endtask

    task automatic exp_add(input int p, input int n, input bit lst);
        for (int i = 0; i < n; i++) begin
            exp_d[exp_n] = mbyte(p + i);
            exp_l[exp_n] = lst && (i == n - 1);
            exp_n = exp_n + 1;
        end
    endtask

    task automatic cmp_stream(input string rq, input int start);
        check(cap_n - start == exp_n, rq, 32'(cap_n - start), 32'(exp_n));
        for (int i = 0; i < exp_n && start + i < cap_n; i++) begin
            check(cap_d[start + i] == exp_d[i], rq, 32'(cap_d[start + i]), 32'(exp_d[i]));
            check(cap_l[start + i] == exp_l[i], {rq, " R5 last"}, 32'(cap_l[start + i]), 32'(exp_l[i]));
        end
    endtask

    initial begin
        int s, b0, f0, r0, k0;
        for (int i = 0; i < 256; i++) begin
            if (i < 128) mem[i] = '0;
            else mem[i] = {mbyte(4*i), mbyte(4*i+1), mbyte(4*i+2), mbyte(4*i+3)};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy, "R1 busy", 32'(busy), 0);
        check(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        check(!tx_valid, "R1 tx_valid", 32'(tx_valid), 0);

        // R2: activate ignored while enable bit is clear
        r0 = n_req;
        cfg_write(2'd2, 32'd0);
        repeat (20) @(negedge clk);
        check(n_req == r0 && !busy, "R2 disabled", 32'(n_req - r0), 0);
        cfg_write(2'd0, 32'h1);
        cfg_write(2'd2, 32'd0);
        repeat (20) @(negedge clk);
        check(n_req == r0 && !busy, "R2 bit0 only", 32'(n_req - r0), 0);
        cfg_write(2'd0, 32'h2);

        // R3 R4 R5 R6 R10: two-buffer frame, unaligned ring start
        cfg_write(2'd1, 32'h103);
        put_desc(32'h100, F_OWN, 16'd5, 32'h200);
        put_desc(32'h108, F_OWN | F_LST, 16'd3, 32'h240);
        put_desc(32'h110, 16'h0000, 16'd0, 32'h0);
        s = cap_n; b0 = n_buf; f0 = n_frm; exp_n = 0;
        exp_add(32'h200, 5, 1'b0);
        exp_add(32'h240, 3, 1'b1);
        activate();
        cmp_stream("R4 R10 two buffers", s);
        check(n_buf - b0 == 2, "R6 buf events", 32'(n_buf - b0), 2);
        check(n_frm - f0 == 1, "R7 frame events", 32'(n_frm - f0), 1);
        check(mem[32'h100 >> 2] == 32'h0000_0005, "R6 writeback d0", mem[32'h100 >> 2], 32'h5);
        check(mem[32'h108 >> 2] == 32'h0800_0003, "R6 writeback d1", mem[32'h108 >> 2], 32'h0800_0003);
        check(mem[32'h110 >> 2] == 32'h0, "R3 stop untouched", mem[32'h110 >> 2], 0);

        // R3 R8: resume at kept pointer, wrap back to ring start
        put_desc(32'h110, F_OWN | F_LST | F_WRP, 16'd4, 32'h280);
        s = cap_n; exp_n = 0;
        exp_add(32'h280, 4, 1'b1);
        activate();
        cmp_stream("R3 resume", s);
        put_desc(32'h100, F_OWN | F_LST, 16'd2, 32'h2c0);
        s = cap_n; exp_n = 0;
        exp_add(32'h2c0, 2, 1'b1);
        activate();
        cmp_stream("R8 wrap", s);

        // R9: truncation at MAXF with babble event
        cfg_write(2'd1, 32'h180);
        put_desc(32'h180, F_OWN, 16'd12, 32'h300);
        put_desc(32'h188, F_OWN | F_LST, 16'd12, 32'h340);
        put_desc(32'h190, 16'h0000, 16'd0, 32'h0);
        s = cap_n; k0 = n_bab; exp_n = 0;
        exp_add(32'h300, 12, 1'b0);
        exp_add(32'h340, MAXF - 12, 1'b1);
        activate();
        cmp_stream("R9 truncate", s);
        check(n_bab - k0 == 1, "R9 babble", 32'(n_bab - k0), 1);
        check(mem[32'h188 >> 2] == 32'h0800_000c, "R6 length kept", mem[32'h188 >> 2], 32'h0800_000c);

        // Sweep of single-buffer wrapping frames, lengths 1..9
        for (int len = 1; len <= 9; len++) begin
            cfg_write(2'd1, 32'h1c0 | 32'(len & 3));
            put_desc(32'h1c0, F_OWN | F_LST | F_WRP, 16'(len), 32'h380);
            s = cap_n; f0 = n_frm; exp_n = 0;
            exp_add(32'h380, len, 1'b1);
            activate();
            cmp_stream("R4 R8 sweep", s);
            check(n_frm - f0 == 1, "R7 sweep frame", 32'(n_frm - f0), 1);
            check(mem[32'h1c0 >> 2] == {16'h2800, 16'(len)}, "R6 sweep writeback",
                  mem[32'h1c0 >> 2], {16'h2800, 16'(len)});
        end
        check(!busy && !tx_valid, "R12 drained", 32'(tx_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule